// File: doc/BRIEF.md
# Secure Write-Protected Register Bank

This block is a byte-wide register bank reached through a plain register-access port. The port has an address, write data, a write strobe, a read strobe and a registered read-data output. Part of the address space is a guarded window. The window holds a group of clock-calendar registers and an eight-byte backup scratch memory. The rest of the address space is ordinary storage.

Two inputs control whether a write into the guarded window is accepted. `lock_en` is the level of a one-time configuration fuse, which is programmed elsewhere. `secure_mode` tells whether the host is currently running trusted code. When the fuse is set and the host is not trusted, a write into the window is dropped and a one-cycle violation pulse is raised. When the fuse is clear, the window behaves like any other storage. Reads are never restricted.

The reset input is asynchronous and active low. Its release is synchronised inside the block, so the bank stays in reset for two clock edges after `rst_n` rises.

Top module: `secbank_top`

## Requirements
- R1: While reset is active, and after it is released, every register reads as zero, `rdata` is zero and `wr_violation` is low.
- R2: A write to an address outside the guarded window (addresses 0 to 15) is always stored, whatever the levels of `secure_mode` and `lock_en`, and it never raises `wr_violation`.
- R3: The guarded window is addresses 16 to 23 (clock-calendar) together with addresses 24 to 31 (backup bytes). With `lock_en`=1 and `secure_mode`=1, a write there is stored.
- R4: With `lock_en`=1 and `secure_mode`=0, a write into the guarded window is refused and the target register keeps its old value. The two levels are taken in the same cycle as the write strobe, so an earlier cycle with `secure_mode`=1 does not authorise the write.
- R5: A refused write drives `wr_violation` high for exactly the one cycle that follows the strobe edge. `wr_violation` is low in every other cycle.
- R6: With `lock_en`=0, a write into the guarded window is stored whatever the level of `secure_mode`, and it raises no violation.
- R7: `rd_en` at a clock edge loads `rdata` with the addressed register, whatever the levels of `secure_mode` and `lock_en`. `rdata` holds its value in every cycle without `rd_en`.
- R8: Write data is committed on the rising clock edge. A read and a write to the same address in the same cycle return the value held before that write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset; release is synchronised inside |
| addr | input | 5 | Register address shared by read and write |
| wdata | input | 8 | Write data |
| wr_en | input | 1 | Write strobe, one cycle per write |
| rd_en | input | 1 | Read strobe; loads rdata at the edge |
| secure_mode | input | 1 | High while the host runs trusted code |
| lock_en | input | 1 | One-time fuse level that turns on write guarding |
| rdata | output | 8 | Registered read data |
| wr_violation | output | 1 | One-cycle pulse after a refused write |

## Verification
The bound checker watches every cycle for the following relations between strobes and outputs:
- a violation pulse follows every refused strobe, and only such a strobe;
- no pulse follows a write to plain storage or a write made with the fuse clear;
- `rdata` never changes without a read strobe;
- outputs are quiet straight after reset.

The checker keeps no copy of the register contents. Only the bench can show that a refused write really left its target unchanged, that accepted writes land in the right register, and that a read in the same cycle as a write returns the old value. The bench shows these with a write-then-read sweep over every address and every combination of the two control levels.

// File: rtl/secbank_pkg.sv
package secbank_pkg;

  // Outcome of the write strobe in the current cycle.
  typedef enum logic [1:0] {
    ACC_IDLE   = 2'd0,
    ACC_COMMIT = 2'd1,
    ACC_REFUSE = 2'd2
  } access_e;

  // True when idx falls in [base, base+count).
  function automatic logic in_span(input int unsigned idx,
                                   input int unsigned base,
                                   input int unsigned count);
    return (idx >= base) && (idx < base + count);
  endfunction

endpackage

// File: rtl/secbank_decode.sv
module secbank_decode
  import secbank_pkg::*;
#(
  parameter int unsigned ADDR_W    = 5,
  parameter int unsigned CAL_BASE  = 16,
  parameter int unsigned CAL_COUNT = 8,
  parameter int unsigned BKP_BASE  = 24,
  parameter int unsigned BKP_COUNT = 8
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              guarded
);

  logic hit_cal;
  logic hit_bkp;

  always_comb begin
    hit_cal = in_span(32'(addr), CAL_BASE, CAL_COUNT);
    hit_bkp = in_span(32'(addr), BKP_BASE, BKP_COUNT);
    guarded = hit_cal | hit_bkp;
  end

endmodule

// File: rtl/secbank_guard.sv
module secbank_guard
  import secbank_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic wr_en,
  input  logic guarded,
  input  logic secure_mode,
  input  logic lock_en,
  output logic commit,
  output logic violation
);

  access_e access;
  logic    violation_d;
  logic    violation_q;

  // Classify the strobe in this cycle.
  always_comb begin
    access = ACC_IDLE;
    if (wr_en) begin
      if (guarded && lock_en && !secure_mode) begin
        access = ACC_REFUSE;
      end else begin
        access = ACC_COMMIT;
      end
    end
  end

  always_comb begin
    commit      = (access == ACC_COMMIT);
    violation_d = (access == ACC_REFUSE);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      violation_q <= 1'b0;
    end else begin
      violation_q <= violation_d;
    end
  end

  assign violation = violation_q;

endmodule

// File: rtl/secbank_store.sv
module secbank_store #(
  parameter int unsigned ADDR_W = 5,
  parameter int unsigned DATA_W = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          commit,
  input  logic [ADDR_W-1:0]             wr_addr,
  input  logic [DATA_W-1:0]             wr_data,
  output logic [(1<<ADDR_W)-1:0][DATA_W-1:0] regs
);

  localparam int unsigned DEPTH = 1 << ADDR_W;

  for (genvar g = 0; g < DEPTH; g++) begin : g_entry
    logic              load;
    logic [DATA_W-1:0] q;

    assign load = commit && (wr_addr == ADDR_W'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        q <= '0;
      end else if (load) begin
        q <= wr_data;
      end
    end

    assign regs[g] = q;
  end

endmodule

// File: rtl/secbank_rdmux.sv
module secbank_rdmux #(
  parameter int unsigned ADDR_W = 5,
  parameter int unsigned DATA_W = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          rd_en,
  input  logic [ADDR_W-1:0]             rd_addr,
  input  logic [(1<<ADDR_W)-1:0][DATA_W-1:0] regs,
  output logic [DATA_W-1:0]             rdata
);

  logic [DATA_W-1:0] rdata_d;
  logic [DATA_W-1:0] rdata_q;

  always_comb begin
    rdata_d = rdata_q;
    if (rd_en) begin
      rdata_d = regs[rd_addr];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
    end else begin
      rdata_q <= rdata_d;
    end
  end

  assign rdata = rdata_q;

endmodule

// File: rtl/secbank_top.sv
module secbank_top #(
  parameter int unsigned ADDR_W    = 5,
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned CAL_BASE  = 16,
  parameter int unsigned CAL_COUNT = 8,
  parameter int unsigned BKP_BASE  = 24,
  parameter int unsigned BKP_COUNT = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic              secure_mode,
  input  logic              lock_en,
  output logic [DATA_W-1:0] rdata,
  output logic              wr_violation
);

  localparam int unsigned DEPTH = 1 << ADDR_W;

  // Reset: asserted at once, released after two clock edges.
  logic [1:0] rst_sync_q;
  logic       rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end

  assign rst_core_n = rst_sync_q[1];

  logic                          guarded;
  logic                          commit;
  logic [DEPTH-1:0][DATA_W-1:0]  regs;

  secbank_decode #(
    .ADDR_W    (ADDR_W),
    .CAL_BASE  (CAL_BASE),
    .CAL_COUNT (CAL_COUNT),
    .BKP_BASE  (BKP_BASE),
    .BKP_COUNT (BKP_COUNT)
  ) u_decode (
    .addr    (addr),
    .guarded (guarded)
  );

  secbank_guard u_guard (
    .clk         (clk),
    .rst_n       (rst_core_n),
    .wr_en       (wr_en),
    .guarded     (guarded),
    .secure_mode (secure_mode),
    .lock_en     (lock_en),
    .commit      (commit),
    .violation   (wr_violation)
  );

  secbank_store #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) u_store (
    .clk     (clk),
    .rst_n   (rst_core_n),
    .commit  (commit),
    .wr_addr (addr),
    .wr_data (wdata),
    .regs    (regs)
  );

  secbank_rdmux #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) u_rdmux (
    .clk     (clk),
    .rst_n   (rst_core_n),
    .rd_en   (rd_en),
    .rd_addr (addr),
    .regs    (regs),
    .rdata   (rdata)
  );

endmodule

// File: rtl/secbank_checker.sv
module secbank_checker
  import secbank_pkg::*;
#(
  parameter int unsigned ADDR_W    = 5,
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned CAL_BASE  = 16,
  parameter int unsigned CAL_COUNT = 8,
  parameter int unsigned BKP_BASE  = 24,
  parameter int unsigned BKP_COUNT = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] addr,
  input logic              wr_en,
  input logic              rd_en,
  input logic              secure_mode,
  input logic              lock_en,
  input logic [DATA_W-1:0] rdata,
  input logic              wr_violation
);

  logic started;
  logic in_window;
  logic refused_now;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      started <= 1'b0;
    end else begin
      started <= 1'b1;
    end
  end

  assign in_window = in_span(32'(addr), CAL_BASE, CAL_COUNT) ||
                     in_span(32'(addr), BKP_BASE, BKP_COUNT);
  assign refused_now = wr_en && lock_en && !secure_mode && in_window;

  AST_QUIET_AFTER_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    !started |-> (rdata == '0 && !wr_violation)); // R1

  AST_PLAIN_NO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (started && $past(wr_en && !in_window)) |-> !wr_violation); // R2

  AST_ONLY_REFUSED_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    (started && wr_violation) |-> $past(refused_now)); // R4

  AST_REFUSE_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    (started && $past(refused_now)) |-> wr_violation); // R5

  AST_BYPASS_NO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (started && $past(wr_en && !lock_en)) |-> !wr_violation); // R6

  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (started && !$past(rd_en)) |-> $stable(rdata)); // R7

endmodule

bind secbank_top secbank_checker #(
  .ADDR_W    (ADDR_W),
  .DATA_W    (DATA_W),
  .CAL_BASE  (CAL_BASE),
  .CAL_COUNT (CAL_COUNT),
  .BKP_BASE  (BKP_BASE),
  .BKP_COUNT (BKP_COUNT)
) u_secbank_checker (
  .clk          (clk),
  .rst_n        (rst_core_n),
  .addr         (addr),
  .wr_en        (wr_en),
  .rd_en        (rd_en),
  .secure_mode  (secure_mode),
  .lock_en      (lock_en),
  .rdata        (rdata),
  .wr_violation (wr_violation)
);

// File: tb/test_secbank_top.sv
module test_secbank_top;

  logic       clk;
  logic       rst_n;
  logic [4:0] addr;
  logic [7:0] wdata;
  logic       wr_en;
  logic       rd_en;
  logic       secure_mode;
  logic       lock_en;
  logic [7:0] rdata;
  logic       wr_violation;

  int checks;
  int errors;
  logic [7:0] model [32];

  secbank_top i_secbank_top (
    .clk          (clk),
    .rst_n        (rst_n),
    .addr         (addr),
    .wdata        (wdata),
    .wr_en        (wr_en),
    .rd_en        (rd_en),
    .secure_mode  (secure_mode),
    .lock_en      (lock_en),
    .rdata        (rdata),
    .wr_violation (wr_violation)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // Called at a falling edge; the write commits at the next rising edge.
  task automatic wr(input logic [4:0] a, input logic [7:0] d, input logic sec, input logic lock);
    addr = a; wdata = d; secure_mode = sec; lock_en = lock; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, input logic sec, input logic lock);
    addr = a; secure_mode = sec; lock_en = lock; rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  initial begin
    checks = 0; errors = 0;
    rst_n = 1'b0; addr = '0; wdata = '0; wr_en = 1'b0; rd_en = 1'b0;
    secure_mode = 1'b0; lock_en = 1'b0;
    for (int i = 0; i < 32; i++) model[i] = 8'h00;
    repeat (3) @(negedge clk);
    chk("R1 rdata in reset", rdata, 8'h00);
    chk("R1 flag in reset", {7'd0, wr_violation}, 8'h00);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 flag after release", {7'd0, wr_violation}, 8'h00);

    // R1: every register is zero after reset.
    for (int a = 0; a < 32; a++) begin
      rd(5'(a), 1'b0, 1'b1);
      chk("R1 register cleared", rdata, 8'h00);
    end

    // Sweep every address against every combination of secure_mode and lock_en.
    for (int a = 0; a < 32; a++) begin
      for (int c = 0; c < 4; c++) begin
        logic sec, lock, prot, refuse;
        logic [7:0] d;
        string tag;
        sec    = c[0];
        lock   = c[1];
        prot   = (a >= 16);
        refuse = prot && lock && !sec;
        d      = 8'(a * 37 + c * 91 + 5);
        if (!prot)      tag = "R2 plain write";
        else if (!lock) tag = "R6 bypass write";
        else if (sec)   tag = "R3 secure write";
        else            tag = "R4 refused write";
        wr(5'(a), d, sec, lock);
        chk("R5 flag after strobe", {7'd0, wr_violation}, {7'd0, refuse});
        if (!refuse) model[a] = d;
        rd(5'(a), ~sec, ~lock);
        chk("R5 flag one cycle only", {7'd0, wr_violation}, 8'h00);
        chk(tag, rdata, model[a]);
      end
    end

    // R4: secure_mode high only in the cycle before the strobe does not authorise the write.
    secure_mode = 1'b1; lock_en = 1'b1;
    @(negedge clk);
    wr(5'd20, 8'hE7, 1'b0, 1'b1);
    chk("R4 level sampled at strobe", {7'd0, wr_violation}, 8'h01);
    rd(5'd20, 1'b1, 1'b1);
    chk("R4 register kept", rdata, model[20]);

    // R7: rdata holds while no read strobe, even with the address and levels changed.
    rd(5'd7, 1'b0, 1'b1);
    chk("R7 read plain", rdata, model[7]);
    addr = 5'd25; secure_mode = 1'b1; lock_en = 1'b0;
    repeat (2) @(negedge clk);
    chk("R7 rdata held", rdata, model[7]);

    // R8: a read and a write to the same address in one cycle return the old value.
    wr(5'd9, 8'h5A, 1'b0, 1'b0);
    model[9] = 8'h5A;
    addr = 5'd9; wdata = 8'hC3; wr_en = 1'b1; rd_en = 1'b1;
    secure_mode = 1'b0; lock_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b0;
    model[9] = 8'hC3;
    chk("R8 same-cycle read gives old", rdata, 8'h5A);
    rd(5'd9, 1'b0, 1'b1);
    chk("R8 new value committed", rdata, 8'hC3);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog expired actual running expected done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule